// File: doc/BRIEF.md
# Collatz Candidate Sieve Generator

This block sits in front of a bank of 3n+1 iterators and decides which starting numbers in a range are worth iterating. A pulse on `go` hands it a base value and a count of consecutive numbers. It walks that range in increasing order and drops three classes of numbers. Even numbers are dropped. Numbers whose residue modulo 3 is 2 are dropped. The third class is numbers whose low bits, looked up in a loadable table, show that the sequence falls below its own start within a few steps. The numbers that survive leave one at a time through a valid/ready handshake. A single-cycle `done` pulse follows the last transfer of the range.

The table holds one bit per odd residue modulo 2^SIEVE_K. It is written through a simple address/data/write-enable port between ranges. The residue modulo 3 is computed once from the base when a range starts. After that it is advanced by a small state step for every odd number visited, so no divider is needed in the walk. The walk, the table lookup and the filter form a pipeline that examines one odd number per clock while the consumer keeps up. The whole pipeline freezes while a candidate waits on `cand_ready`.

Top module: `collatz_sieve`

## Requirements
- R1: `cand_num` is always odd whenever `cand_valid` is high.
- R2: No number n with n mod 3 equal to 2 is ever presented.
- R3: Table entry `i` (written with `tbl_addr` = i) covers odd numbers n whose bits SIEVE_K-1 down to 1 equal i. A stored 1 drops n. A stored 0 lets n through. Every odd n in the range with n mod 3 in {0,1} and a 0 entry is presented exactly once.
- R4: The range is base .. base+len-1. Base may be even or odd, and base+len must not exceed 2^NUM_W. Candidates appear in strictly increasing order.
- R5: While `cand_valid` is high and `cand_ready` is low, `cand_valid` stays high and `cand_num` holds its value. A transfer happens on a clock edge where both are high.
- R6: `done` is high for exactly one cycle per range. It comes after the final transfer, never while `cand_valid` is high. It also comes for ranges that contain no odd number, including len = 0.
- R7: A `go` pulse that arrives while a range is still in progress, up to and including its `done` cycle, is ignored.
- R8: With `cand_ready` held high and a range holding N > 0 odd numbers, `done` is observed N+2 clock edges after the edge that accepts `go`.
- R9: After reset, `cand_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a range; accepted only when idle |
| cfg_base | input | NUM_W | First number of the range |
| cfg_len | input | LEN_W | Count of consecutive numbers in the range |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | SIEVE_K-1 | Table entry index (odd residue >> 1) |
| tbl_din | input | 1 | Table bit: 1 drops, 0 keeps |
| cand_valid | output | 1 | Candidate present |
| cand_ready | input | 1 | Consumer accepts candidate |
| cand_num | output | NUM_W | Candidate starting number |
| done | output | 1 | One-cycle end-of-range pulse |

## Verification
The assertions assume three things about the inputs. The range never wraps past 2^NUM_W. The table is not rewritten while a range is being walked. A strictly increasing order is expected only within one range, so the ordering check restarts at each `done`. The stimulus loads the table only between ranges. It picks bases and lengths that stay below the top of the 64-bit space, including one range just under it. A second `go` is issued only deliberately, in the middle of a range, to show that it is ignored. The consumer side is driven both always-ready and with a pseudo-random ready pattern, so the hold rule and the frozen pipeline are exercised at every stage.

// File: rtl/cs_pkg.sv
// Shared types and helpers for the Collatz candidate sieve.
// Assumes numbers are at most 128 bits wide.
package cs_pkg;

    // Side information travelling with a number through the pipeline
    typedef struct packed {
        logic       vld;   // slot holds a number
        logic       last;  // final odd number of the range
        logic [1:0] m3;    // residue of the number modulo 3
    } tag_t;

    // Residue modulo 3 of a wide value: 2^i mod 3 is 1 for even i, 2 for odd i
    function automatic logic [1:0] mod3_of(input logic [127:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 0; i < 128; i++) begin
            if (v[i]) begin
                r = r + (i[0] ? 3'd2 : 3'd1);
                if (r >= 3'd3) r = r - 3'd3;
            end
        end
        return r[1:0];
    endfunction

    // Residue after adding k (k in 0..2) to a value with residue m
    function automatic logic [1:0] mod3_add(input logic [1:0] m, input logic [1:0] k);
        logic [2:0] s;
        s = {1'b0, m} + {1'b0, k};
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

endpackage

// File: rtl/cs_walker.sv
// Range walker: steps through the odd numbers of [base, base+len) in order.
// Keeps the residue mod 3 incrementally (+2 per step) after a one-time
// reduction of the base. Assumes base+len does not wrap past 2^NUM_W.
module cs_walker #(
    parameter int NUM_W = 64,
    parameter int LEN_W = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,        // accepted go
    input  logic [NUM_W-1:0] base,
    input  logic [LEN_W-1:0] len,
    input  logic             adv,          // pipeline advances this edge
    output cs_pkg::tag_t     tag,          // current slot information
    output logic [NUM_W-1:0] num,          // current odd number
    output logic             start_empty,  // accepted range holds no odd number
    output logic             active
);
    logic [LEN_W-1:0] remain;
    logic [LEN_W:0]   n_odd;
    logic [1:0]       base_m3;
    logic [1:0]       m3;

    // Count of odd numbers in the range and residue of the first one
    always_comb begin
        n_odd   = base[0] ? (({1'b0, len} + 1'b1) >> 1) : ({1'b0, len} >> 1);
        base_m3 = cs_pkg::mod3_of(128'(base));
    end

    assign start_empty = start && (n_odd == '0);

    // Walk state: load on start, step by two on each advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
            num    <= '0;
            m3     <= 2'd0;
        end else if (start) begin
            active <= (n_odd != '0);
            remain <= n_odd[LEN_W-1:0];
            num    <= base | NUM_W'(1);
            m3     <= base[0] ? base_m3 : cs_pkg::mod3_add(base_m3, 2'd1);
        end else if (active && adv) begin
            active <= (remain != LEN_W'(1));
            remain <= remain - 1'b1;
            num    <= num + NUM_W'(2);
            m3     <= cs_pkg::mod3_add(m3, 2'd2);
        end
    end

    assign tag = '{vld: active, last: (remain == LEN_W'(1)), m3: m3};

endmodule

// File: rtl/cs_sieve_ram.sv
// Sieve table: one bit per odd residue, synchronous write and enabled
// synchronous read. Assumes it is not written while a range is walked.
module cs_sieve_ram #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] bits_q;

    // Table write port
    always_ff @(posedge clk) begin
        if (we) bits_q[waddr] <= wdata;
    end

    // Read port, held when the pipeline is frozen
    always_ff @(posedge clk) begin
        if (re) rdata <= bits_q[raddr];
    end

endmodule

// File: rtl/collatz_sieve.sv
// Collatz candidate sieve: walks a range, drops even numbers, numbers
// congruent to 2 mod 3 and numbers flagged by the sieve table, and hands
// the rest out through valid/ready, followed by one end-of-range pulse.
// Assumes SIEVE_K >= 2, NUM_W <= 128 and no table writes during a range.
module collatz_sieve #(
    parameter int NUM_W   = 64,
    parameter int LEN_W   = 35,
    parameter int SIEVE_K = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [NUM_W-1:0]   cfg_base,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               tbl_we,
    input  logic [SIEVE_K-2:0] tbl_addr,
    input  logic               tbl_din,
    output logic               cand_valid,
    input  logic               cand_ready,
    output logic [NUM_W-1:0]   cand_num,
    output logic               done
);
    localparam int ADDR_W = SIEVE_K - 1;

    cs_pkg::tag_t     wk_tag;
    logic [NUM_W-1:0] wk_num;
    logic             wk_active;
    logic             start_empty;
    cs_pkg::tag_t     s1_tag;
    logic [NUM_W-1:0] s1_num;
    logic             drop_bit;
    logic             last_pend;
    logic             busy;
    logic             start;
    logic             adv;
    logic             keep;

    // Idle detection, go acceptance and pipeline advance
    always_comb begin
        busy  = wk_active || s1_tag.vld || cand_valid || last_pend || done;
        start = go && !busy;
        adv   = !cand_valid || cand_ready;
        keep  = s1_tag.vld && (s1_tag.m3 != 2'd2) && !drop_bit;
    end

    cs_walker #(.NUM_W(NUM_W), .LEN_W(LEN_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .base        (cfg_base),
        .len         (cfg_len),
        .adv         (adv),
        .tag         (wk_tag),
        .num         (wk_num),
        .start_empty (start_empty),
        .active      (wk_active)
    );

    cs_sieve_ram #(.ADDR_W(ADDR_W)) u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_din),
        .re    (adv),
        .raddr (wk_num[SIEVE_K-1:1]),
        .rdata (drop_bit)
    );

    // Lookup stage: number and tag aligned with the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_tag <= '0;
            s1_num <= '0;
        end else if (adv) begin
            s1_tag <= wk_tag;
            s1_num <= wk_num;
        end
    end

    // Output slot: loads survivors, holds while the consumer stalls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_valid <= 1'b0;
            cand_num   <= '0;
        end else if (adv) begin
            cand_valid <= keep;
            cand_num   <= s1_num;
        end
    end

    // End-of-range tracking: pulse once the final slot has drained
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pend <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= last_pend && adv;
            if (start_empty || (adv && s1_tag.vld && s1_tag.last))
                last_pend <= 1'b1;
            else if (last_pend && adv)
                last_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/collatz_sieve_chk.sv
// Protocol and ordering checks for collatz_sieve, attached by bind.
// Assumes ranges do not wrap and ordering is judged within one range.
module collatz_sieve_chk #(
    parameter int NUM_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cand_valid,
    input logic             cand_ready,
    input logic [NUM_W-1:0] cand_num,
    input logic             done
);
    logic             have_prev;
    logic [NUM_W-1:0] prev_num;

    // Last transferred number of the current range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_num  <= '0;
        end else if (done) begin
            have_prev <= 1'b0;
        end else if (cand_valid && cand_ready) begin
            have_prev <= 1'b1;
            prev_num  <= cand_num;
        end
    end

    // R1
    odd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> cand_num[0]);

    // R2
    mod3_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (cand_num % 3) != 2);

    // R4
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_ready && have_prev) |-> cand_num > prev_num);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !cand_ready) |=> (cand_valid && $stable(cand_num)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cand_valid);

endmodule

bind collatz_sieve collatz_sieve_chk #(.NUM_W(NUM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_valid (cand_valid),
    .cand_ready (cand_ready),
    .cand_num   (cand_num),
    .done       (done)
);

// File: tb/collatz_sieve_test.sv
// Scoreboard bench: the range task queues expected candidates,
// the negedge monitor pops and compares each transfer.
module collatz_sieve_test;
    localparam int NW    = 64;
    localparam int LW    = 35;
    localparam int K     = 10;
    localparam int DEPTH = 1 << (K - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [NW-1:0] cfg_base = '0;
    logic [LW-1:0] cfg_len = '0;
    logic          tbl_we = 1'b0;
    logic [K-2:0]  tbl_addr = '0;
    logic          tbl_din = 1'b0;
    logic          cand_valid;
    logic          cand_ready = 1'b1;
    logic [NW-1:0] cand_num;
    logic          done;

    bit            tblm [DEPTH];
    logic [NW-1:0] expq [$];
    int            errors = 0;
    int            checks = 0;
    int            done_cnt = 0;
    int            cyc = 0;
    bit            stall_mode = 1'b0;
    bit            mon_en = 1'b0;
    bit            hold_prev = 1'b0;
    logic [NW-1:0] held_num = '0;
    logic [15:0]   lfsr = 16'hACE1;
    bit            finished = 1'b0;

    always #2.5 clk = ~clk;

    collatz_sieve #(.NUM_W(NW), .LEN_W(LW), .SIEVE_K(K)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_din(tbl_din),
        .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_num(cand_num),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [NW-1:0] act,
                       input logic [NW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", NW'(cyc), 64'd150000);
            finish_run();
        end
    end

    // Monitor: hold check, ready drive, transfer compare, done tracking
    always @(negedge clk) begin
        if (mon_en) begin
            if (hold_prev)
                chk(cand_valid && cand_num == held_num, "R5 hold", cand_num, held_num);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cand_ready = stall_mode ? lfsr[0] : 1'b1;
            hold_prev = cand_valid && !cand_ready;
            held_num = cand_num;
            if (cand_valid && cand_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3 unexpected candidate", cand_num, '0);
                end else begin
                    logic [NW-1:0] e;
                    e = expq.pop_front();
                    chk(cand_num == e, "R3/R4 candidate", cand_num, e);
                end
            end
            if (done) begin
                done_cnt++;
                chk(!cand_valid, "R6 done with valid", NW'(cand_valid), '0);
            end
        end
    end

    // Load the table; pattern 0 all keep, 1 sparse drops, 2 all drop
    task automatic load_table(input int pattern);
        for (int i = 0; i < DEPTH; i++) begin
            bit b;
            b = (pattern == 0) ? 1'b0 : (pattern == 1) ? ((i * 7 + 3) % 5 == 0) : 1'b1;
            tblm[i] = b;
            @(negedge clk);
            tbl_we = 1'b1;
            tbl_addr = (K-1)'(i);
            tbl_din = b;
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Run one range; interfere issues a stray go mid-range (R7);
    // exp_edges >= 0 checks the done latency (R8)
    task automatic run_range(input logic [NW-1:0] base, input logic [LW-1:0] len,
                             input bit stall, input bit interfere, input int exp_edges);
        int edges;
        expq.delete();
        for (longint unsigned i = 0; i < 64'(len); i++) begin
            logic [NW-1:0] n;
            n = base + NW'(i);
            if (n[0] && (n % 3) != 2 && !tblm[n[K-1:1]]) expq.push_back(n);
        end
        stall_mode = stall;
        done_cnt = 0;
        @(negedge clk);
        cfg_base = base;
        cfg_len = len;
        go = 1'b1;
        @(negedge clk);
        edges = 0;
        go = 1'b0;
        while (!done && edges < 40000) begin
            go = interfere && (edges == 3);
            if (go) begin
                cfg_base = 64'd5;
                cfg_len = LW'(40);
            end
            @(negedge clk);
            edges++;
        end
        go = 1'b0;
        chk(done, "R6 done seen", NW'(done), 64'd1);
        if (exp_edges >= 0)
            chk(edges == exp_edges, "R8 latency", NW'(edges), NW'(exp_edges));
        chk(expq.size() == 0, "R3 all candidates delivered", NW'(expq.size()), '0);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R6 single pulse", NW'(done_cnt), 64'd1);
        chk(!cand_valid, "R7 nothing after done", NW'(cand_valid), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet in reset and right after
        chk(!cand_valid && !done, "R9 reset state", NW'({cand_valid, done}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cand_valid && !done, "R9 after reset", NW'({cand_valid, done}), '0);
        mon_en = 1'b1;

        load_table(0);
        // R8: 100 numbers from 1, 50 odd numbers, ready always high
        run_range(64'd1, LW'(100), 1'b0, 1'b0, 52);
        // R1 R2: even base, random stall
        run_range(64'd1000, LW'(257), 1'b1, 1'b0, -1);

        load_table(1);
        // R3: sparse drops, range wraps through the table index
        run_range(64'd1000, LW'(257), 1'b1, 1'b0, -1);
        // R4: base close to the top of the number space, odd base
        run_range(64'hFFFF_FFFF_FFFF_F001, LW'(300), 1'b1, 1'b0, -1);
        // R7: stray go during a range is ignored
        run_range(64'd77777, LW'(200), 1'b1, 1'b1, -1);
        // R6: empty and single-number ranges
        run_range(64'd40, LW'(0), 1'b0, 1'b0, 1);
        run_range(64'd42, LW'(1), 1'b0, 1'b0, 1);
        run_range(64'd7, LW'(1), 1'b0, 1'b0, -1);

        load_table(2);
        // R3: every entry drops, nothing presented
        run_range(64'd3, LW'(150), 1'b0, 1'b0, -1);

        finish_run();
    end

endmodule